// File: doc/BRIEF.md
# Pseudo-Random Pixel Dithering Unit

This block narrows a stream of 24-bit colour pixels (8 bits each of red, green and blue) to 18 bits (6 bits per channel) for a panel with fewer colour bits. Simply dropping the two low bits of each channel would leave visible banding. Instead, each channel is compared with a small random threshold, and the kept part is rounded up when the dropped bits reach that threshold. Because the thresholds change from pixel to pixel and from frame to frame, the rounding error averages out over time and space.

A 16-bit linear feedback shift register supplies all three thresholds. It waits at its seed until the display pipeline marks the first active pixel. After that it advances on every pixel clock, through blanking and while dithering is switched off, so the random sequence does not depend on the picture content. Dropping the controller enable puts the register back to its seed. The result is registered once, and the valid flag travels with it.

Top module: `pix_dither`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_pix` become 0 and the random register returns to its seed 16'hACE1 in the idle (not started) state.
- R2: Pixels are packed red in bits [23:16], green in [15:8] and blue in [7:0] at the input. The output packs red in [17:12], green in [11:6] and blue in [5:0]. Each output channel is derived only from the same input channel.
- R3: With `dith_en` high, an output channel equals the upper 6 bits of its input channel plus one when the dropped 2 bits are greater than or equal to the threshold. The red threshold is register bits [5:4], green is [3:2] and blue is [1:0].
- R4: The round-up saturates: an upper part of 6'h3F stays 6'h3F and never wraps to 0.
- R5: With `dith_en` low, each output channel is the plain upper 6 bits of its input channel.
- R6: Once started, the register shifts left by one on every clock. The new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R7: With `ctrl_en` high, the register holds its seed until a cycle with `first_px` high. That cycle's pixel uses the seed thresholds, and the register starts advancing from that edge.
- R8: Once started, the register keeps advancing in cycles with `in_valid` low and in cycles with `dith_en` low.
- R9: A clock edge with `ctrl_en` low returns the register to its seed and to the idle state, so a new `first_px` is needed to restart it.
- R10: `out_pix` and `out_valid` reflect the inputs sampled at the previous clock edge (one cycle of latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_en | input | 1 | Display controller enable; low resets the random register |
| dith_en | input | 1 | Dithering on (1) or plain truncation (0) |
| first_px | input | 1 | Strobe marking the first active pixel |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 24 | Input pixel {R8,G8,B8} |
| out_valid | output | 1 | Output pixel qualifier, delayed one cycle |
| out_pix | output | 18 | Output pixel {R6,G6,B6} |

## Verification
The bench aims at the start point of the random sequence. A register that advanced before the first-pixel strobe, or that skipped the strobe cycle, would apply shifted thresholds and mismatch the reference on random pixels. It keeps the register running through blanking and dither-off stretches, then checks dithered pixels afterwards, so a design that froze the register in those stretches would show the wrong rounding. Near-white inputs probe saturation, where a wrapping adder would return 0. Disable-then-re-enable sequences catch a register that is not reseeded, or that restarts without a new strobe.

// File: rtl/dith_pkg.sv
// Package: shared dimensions and constants of the dithering unit.
// Assumes three colour channels, each narrowed by the same number of bits.
package dith_pkg;
    localparam int CH_IN_W   = 8;
    localparam int CH_OUT_W  = 6;
    localparam int NUM_CH    = 3;
    localparam int LFSR_W    = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    // Feedback mask: bits 15, 13, 12, 10 (polynomial x^16+x^14+x^13+x^11+1)
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/dith_lfsr.sv
// Module: dith_lfsr
// Fibonacci shift register that supplies the random thresholds.
// It holds its seed until first_px arrives with ctrl_en high, and after that
// it shifts on every clock. ctrl_en low or reset returns it to the seed.
// Assumes SEED is nonzero and TAPS describes a maximal-length polynomial.
module dith_lfsr #(
    parameter int               W    = dith_pkg::LFSR_W,
    parameter logic [W-1:0]     SEED = dith_pkg::LFSR_SEED,
    parameter logic [W-1:0]     TAPS = dith_pkg::LFSR_TAPS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_en,
    input  logic         first_px,
    output logic [W-1:0] state,
    output logic         started
);
    logic feedback;
    logic advance;

    // Feedback bit: parity of the tapped state bits
    always_comb feedback = ^(state & TAPS);

    // Shift on the strobe cycle and on every cycle after it
    always_comb advance = ctrl_en & (started | first_px);

    // Register update: reseed when reset or disabled, else shift when running
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_en) begin
            state   <= SEED;
            started <= 1'b0;
        end else begin
            if (advance) begin
                state <= {state[W-2:0], feedback};
            end
            if (first_px) begin
                started <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dith_channel.sv
// Module: dith_channel
// Combinational narrowing of one colour channel. The kept upper bits are
// rounded up when dithering is on and the dropped bits reach the threshold.
// The increment saturates at all-ones. Assumes IN_W > OUT_W.
module dith_channel #(
    parameter int IN_W  = dith_pkg::CH_IN_W,
    parameter int OUT_W = dith_pkg::CH_OUT_W,
    localparam int DROP_W = IN_W - OUT_W
) (
    input  logic [IN_W-1:0]   din,
    input  logic [DROP_W-1:0] thr,
    input  logic              dith_en,
    output logic [OUT_W-1:0]  dout
);
    logic [OUT_W-1:0]  kept;
    logic [DROP_W-1:0] lost;
    logic              bump;

    // Split the channel into its kept and dropped parts
    always_comb begin
        kept = din[IN_W-1:DROP_W];
        lost = din[DROP_W-1:0];
    end

    // Round-up decision, suppressed at the top code
    always_comb bump = dith_en && (lost >= thr) && (kept != {OUT_W{1'b1}});

    // Narrowed result
    always_comb dout = kept + OUT_W'(bump);
endmodule

// File: rtl/pix_dither.sv
// Module: pix_dither (top)
// Narrows {R,G,B} pixels from CH_IN_W to CH_OUT_W bits per channel using
// per-channel random thresholds. Output and valid are registered once.
// Assumes the random register is wide enough for NUM_CH thresholds.
module pix_dither #(
    parameter int IN_W   = dith_pkg::CH_IN_W,
    parameter int OUT_W  = dith_pkg::CH_OUT_W,
    parameter int NCH    = dith_pkg::NUM_CH,
    parameter int RW     = dith_pkg::LFSR_W,
    localparam int DROP_W = IN_W - OUT_W,
    localparam int PIX_IN_W  = IN_W * NCH,
    localparam int PIX_OUT_W = OUT_W * NCH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_en,
    input  logic                 dith_en,
    input  logic                 first_px,
    input  logic                 in_valid,
    input  logic [PIX_IN_W-1:0]  in_pix,
    output logic                 out_valid,
    output logic [PIX_OUT_W-1:0] out_pix
);
    logic [RW-1:0]        lfsr_q;
    logic                 lfsr_run;
    logic [PIX_OUT_W-1:0] narrow;

    dith_lfsr #(
        .W    (RW),
        .SEED (dith_pkg::LFSR_SEED),
        .TAPS (dith_pkg::LFSR_TAPS)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_en  (ctrl_en),
        .first_px (first_px),
        .state    (lfsr_q),
        .started  (lfsr_run)
    );

    // One narrowing slice per channel; slot 0 is blue, the top slot is red
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dith_channel #(
            .IN_W  (IN_W),
            .OUT_W (OUT_W)
        ) u_ch (
            .din     (in_pix[i*IN_W +: IN_W]),
            .thr     (lfsr_q[i*DROP_W +: DROP_W]),
            .dith_en (dith_en),
            .dout    (narrow[i*OUT_W +: OUT_W])
        );
    end

    // Output stage: one cycle of latency for pixel and qualifier
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            out_pix   <= narrow;
        end
    end
endmodule

// File: rtl/pix_dither_chk.sv
// Module: pix_dither_chk
// Property checker for pix_dither, attached by bind below.
module pix_dither_chk #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 6,
    parameter int NCH   = 3,
    parameter int RW    = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ctrl_en,
    input logic                  dith_en,
    input logic                  first_px,
    input logic                  in_valid,
    input logic [IN_W*NCH-1:0]   in_pix,
    input logic                  out_valid,
    input logic [OUT_W*NCH-1:0]  out_pix,
    input logic [RW-1:0]         lfsr_state,
    input logic                  lfsr_started
);
    localparam int DW = IN_W - OUT_W;

    // R9
    reseed_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (lfsr_state == dith_pkg::LFSR_SEED) && !lfsr_started);

    // R7
    hold_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !lfsr_started && !first_px) |=> $stable(lfsr_state));

    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

    // R10
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    invalid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    for (genvar i = 0; i < NCH; i++) begin : g_p
        // R5
        trunc_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dith_en |=> out_pix[i*OUT_W +: OUT_W] == $past(in_pix[i*IN_W+DW +: OUT_W]));

        // R3
        round_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ({1'b0, out_pix[i*OUT_W +: OUT_W]} == {1'b0, $past(in_pix[i*IN_W+DW +: OUT_W])}) ||
                     ({1'b0, out_pix[i*OUT_W +: OUT_W]} == {1'b0, $past(in_pix[i*IN_W+DW +: OUT_W])} + 1'b1));
    end
endmodule

bind pix_dither pix_dither_chk #(
    .IN_W  (IN_W),
    .OUT_W (OUT_W),
    .NCH   (NCH),
    .RW    (RW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctrl_en      (ctrl_en),
    .dith_en      (dith_en),
    .first_px     (first_px),
    .in_valid     (in_valid),
    .in_pix       (in_pix),
    .out_valid    (out_valid),
    .out_pix      (out_pix),
    .lfsr_state   (lfsr_q),
    .lfsr_started (lfsr_run)
);

// File: tb/pix_dither_bench.sv
// Bench: behavioural reference of the requirements, compared every cycle.
module pix_dither_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b0;
    logic        dith_en = 1'b0;
    logic        first_px = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pix = '0;
    logic        out_valid;
    logic [17:0] out_pix;

    int   n_checks = 0;
    int   n_fail = 0;
    int   m_lfsr = 16'hACE1;
    bit   m_run = 1'b0;
    int   exp_valid = 0;
    int   exp_ch [3] = '{0, 0, 0};
    string exp_tag [3] = '{"R1", "R1", "R1"};
    string phase = "R1";
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_dither u_pix_dither (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_en   (ctrl_en),
        .dith_en   (dith_en),
        .first_px  (first_px),
        .in_valid  (in_valid),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s phase %s: actual %0h expected %0h at %0t", tag, phase, act, exp, $time);
        end
    endtask

    // Compare outputs with the prediction, then apply new inputs and predict.
    task automatic cyc(input bit r, input bit ce, input bit de, input bit fp,
                       input bit v, input logic [23:0] p);
        @(negedge clk);
        check_eq("R10 valid", int'(out_valid), exp_valid);
        for (int c = 0; c < 3; c++) begin
            check_eq({exp_tag[c], " ch"}, int'(out_pix[c*6 +: 6]), exp_ch[c]);
        end
        rst_n = r; ctrl_en = ce; dith_en = de; first_px = fp; in_valid = v; in_pix = p;
        if (!r) begin
            exp_valid = 0;
            for (int c = 0; c < 3; c++) begin exp_ch[c] = 0; exp_tag[c] = "R1"; end
            m_lfsr = 16'hACE1; m_run = 1'b0;
        end else begin
            exp_valid = v;
            for (int c = 0; c < 3; c++) begin
                int up = (p >> (c*8 + 2)) & 63;
                int lo = (p >> (c*8)) & 3;
                int th = (m_lfsr >> (c*2)) & 3;
                if (!de) exp_tag[c] = "R5 R2";
                else if (up == 63) exp_tag[c] = "R4";
                else exp_tag[c] = "R3";
                if (de && lo >= th && up < 63) up++;
                exp_ch[c] = up;
            end
            // R6 R7 R9: register evolution per requirement
            if (!ce) begin
                m_lfsr = 16'hACE1; m_run = 1'b0;
            end else if (m_run || fp) begin
                int fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
                m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
                m_run = 1'b1;
            end
        end
    endtask

    task automatic run_rand(input int n, input bit de, input int vmode);
        for (int k = 0; k < n; k++) begin
            bit v = (vmode == 2) ? bit'($urandom_range(0, 1)) : bit'(vmode);
            cyc(1, 1, de, 0, v, 24'($urandom));
        end
    endtask

    initial begin
        phase = "R1";
        for (int k = 0; k < 4; k++) cyc(0, 1, 1, 0, 1, 24'hFFFFFF);
        phase = "R7";
        run_rand(20, 1, 1);
        cyc(1, 1, 1, 1, 1, 24'h030303);
        phase = "R6";
        run_rand(200, 1, 2);
        phase = "R8";
        for (int k = 0; k < 100; k++) cyc(1, 1, bit'($urandom_range(0, 1)), 0, 0, 24'($urandom));
        for (int k = 0; k < 40; k++) cyc(1, 1, 0, 0, 1, 24'($urandom));
        run_rand(60, 1, 1);
        phase = "R4";
        for (int k = 0; k < 60; k++) begin
            logic [23:0] p;
            for (int c = 0; c < 3; c++) p[c*8 +: 8] = 8'hFC | 8'($urandom_range(0, 3));
            cyc(1, 1, 1, 0, 1, p);
        end
        phase = "R2";
        cyc(1, 1, 0, 0, 1, 24'hFF0000);
        cyc(1, 1, 0, 0, 1, 24'h00FF00);
        cyc(1, 1, 0, 0, 1, 24'h0000FF);
        cyc(1, 1, 1, 0, 1, 24'h7F7F7F);
        phase = "R5";
        run_rand(40, 0, 1);
        phase = "R9";
        for (int k = 0; k < 10; k++) cyc(1, 0, 1, bit'($urandom_range(0, 1)), 1, 24'($urandom));
        run_rand(15, 1, 1);
        cyc(1, 1, 1, 1, 1, 24'($urandom));
        run_rand(100, 1, 2);
        cyc(1, 0, 1, 0, 1, 24'($urandom));
        cyc(1, 1, 1, 1, 1, 24'($urandom));
        run_rand(50, 1, 1);
        phase = "R1";
        cyc(0, 1, 1, 0, 1, 24'($urandom));
        cyc(1, 1, 1, 0, 1, 24'($urandom));
        cyc(1, 1, 1, 0, 0, 24'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule